// File: doc/BRIEF.md
# Transactional Conflict List Tracker

This block sits beside one core of a chip multiprocessor that supports hardware transactions. It holds the core's transactional read and write sets as one speculative-read bit and one speculative-modified bit per cache line. It also holds two per-core bit vectors. The victim vector lists the remote cores whose transactions this core must kill if it commits first. The threat vector lists the remote cores that may kill this core's transaction. Conflicts are detected eagerly: as soon as the coherence layer reports that a line is shared with a remote transaction, the bits are set. They are resolved lazily: nothing is done with them until commit.

At commit the tracker takes a snapshot of the victim vector. It sends one abort pulse to all of those cores at once and waits until each of them has acknowledged. A commit with an empty victim vector finishes one cycle after the request, with no message exchange, so transactions that do not conflict commit in parallel. An abort from a remote committer is always acknowledged. It discards a live transaction, and it wins over a commit still waiting for acknowledgements. Every way a transaction ends clears all line bits and both vectors in a single cycle.

Top module: `tmc_tracker`

## Requirements
- R1: After reset the tracker is idle (`tx_active_o`=0), both vectors read zero, and `abort_vec_o`, `commit_done_o`, `aborted_o` and `rab_ack_valid_o` are 0.
- R2: While a transaction runs, `rd_i` sets the speculative-read bit of `rd_line_i` and `wr_i` sets the speculative-modified bit of `wr_line_i`. Accesses while idle set nothing. `q_sr_o`/`q_sm_o` show the bits of `q_line_i` one cycle after it is presented.
- R3: A conflict notice sets nothing in these cases: both sides only read (`cf_local_wr_i`=0, `cf_remote_wr_i`=0); it names this core's own index; or it arrives while no transaction runs.
- R4: A running-transaction notice with `cf_local_wr_i`=1 sets bit `cf_core_i` of `racers_o` one cycle later.
- R5: A running-transaction notice with `cf_remote_wr_i`=1 sets bit `cf_core_i` of `killers_o`. A write-write notice sets the bit in both vectors.
- R6: A commit with an empty victim vector raises `commit_done_o` for one cycle in the cycle after the request and never drives `abort_vec_o`.
- R7: A commit with victims drives `abort_vec_o` equal to the victim vector for exactly one cycle. `commit_done_o` then rises only in the cycle after the last acknowledgement from a snapshot member. Acknowledgements from cores outside the snapshot count for nothing.
- R8: A remote abort is acknowledged the next cycle on `rab_ack_valid_o` with `rab_ack_dst_o` equal to the source. If a transaction was live, it pulses `aborted_o` and ends the transaction. If the tracker was idle, it only acknowledges.
- R9: A remote abort that arrives while a commit waits for acknowledgements wins, even in the same cycle as the final acknowledgement. The result is `aborted_o`=1 and `commit_done_o`=0.
- R10: When a transaction ends by commit or by abort, every line bit and both vectors are zero in the cycle that shows the outcome pulse.
- R11: A local abort (`tx_abort_i`) of a running transaction pulses `aborted_o` and discards all of its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin_i | input | 1 | Local core starts a transaction |
| tx_commit_i | input | 1 | Local core requests commit |
| tx_abort_i | input | 1 | Local core abandons its transaction |
| rd_i | input | 1 | Transactional read |
| rd_line_i | input | LW | Line index of the read |
| wr_i | input | 1 | Transactional write |
| wr_line_i | input | LW | Line index of the write |
| cf_valid_i | input | 1 | Sharing notice from the coherence layer |
| cf_core_i | input | CW | Remote core sharing the line |
| cf_local_wr_i | input | 1 | This core wrote the shared line |
| cf_remote_wr_i | input | 1 | The remote core wrote the shared line |
| rab_valid_i | input | 1 | Abort arriving from a remote committer |
| rab_src_i | input | CW | Index of that committer |
| ack_valid_i | input | 1 | Acknowledgement of one of our aborts |
| ack_src_i | input | CW | Core that acknowledged |
| q_line_i | input | LW | Line whose set bits are read out |
| tx_active_o | output | 1 | A transaction is running or committing |
| racers_o | output | NCORES | Victim vector |
| killers_o | output | NCORES | Threat vector |
| abort_vec_o | output | NCORES | One-cycle abort pulse, one bit per target core |
| commit_done_o | output | 1 | Commit finished (one cycle) |
| aborted_o | output | 1 | Transaction discarded (one cycle) |
| rab_ack_valid_o | output | 1 | Acknowledgement of a remote abort |
| rab_ack_dst_o | output | CW | Core that receives the acknowledgement |
| q_sr_o | output | 1 | Speculative-read bit of q_line_i |
| q_sm_o | output | 1 | Speculative-modified bit of q_line_i |

## Verification
Some properties are checked on every cycle:
- an idle tracker holds no line bits and no vector bits;
- the own-core bit never enters the victim vector;
- the abort pulse lasts one cycle and copies the victim vector of the cycle before;
- commit and abort outcomes never coincide;
- no commit finishes out of idle.

Other behaviour only the directed scenarios can show. This covers waiting for the exact acknowledgement set while ignoring strangers, the abort winning in the final-acknowledgement cycle, the read-read and self-notice cases recording nothing, and the per-line bits read back through the query port before and after a transaction ends.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } tx_st_e;
endpackage

// File: rtl/tmc_line_sets.sv
module tmc_line_sets #(
  parameter int NLINES = 64,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          idle_i,
  input  logic          rd_i,
  input  logic [LW-1:0] rd_line_i,
  input  logic          wr_i,
  input  logic [LW-1:0] wr_line_i,
  input  logic [LW-1:0] q_line_i,
  output logic          q_sr_o,
  output logic          q_sm_o
);
  logic [NLINES-1:0] sr_q;
  logic [NLINES-1:0] sm_q;

  // one flop pair per line: flash clear rules out a RAM array
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        sr_q[g] <= 1'b0;
        sm_q[g] <= 1'b0;
      end else if (en_i) begin
        if (rd_i && rd_line_i == LW'(g)) sr_q[g] <= 1'b1;
        if (wr_i && wr_line_i == LW'(g)) sm_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_sr_o <= 1'b0;
      q_sm_o <= 1'b0;
    end else begin
      q_sr_o <= sr_q[q_line_i];
      q_sm_o <= sm_q[q_line_i];
    end
  end

  AST_SETS_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle_i |-> (sr_q == '0 && sm_q == '0)); // R10
endmodule

// File: rtl/tmc_core_vecs.sv
module tmc_core_vecs #(
  parameter int NCORES  = 32,
  parameter int CORE_ID = 0,
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              idle_i,
  input  logic              cf_valid_i,
  input  logic [CW-1:0]     cf_core_i,
  input  logic              cf_local_wr_i,
  input  logic              cf_remote_wr_i,
  output logic [NCORES-1:0] racers_o,
  output logic [NCORES-1:0] killers_o
);
  logic take;
  assign take = en_i && cf_valid_i && (cf_core_i != CW'(CORE_ID));

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      racers_o  <= '0;
      killers_o <= '0;
    end else if (take) begin
      if (cf_local_wr_i)  racers_o[cf_core_i]  <= 1'b1;
      if (cf_remote_wr_i) killers_o[cf_core_i] <= 1'b1;
    end
  end

  AST_VECS_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle_i |-> (racers_o == '0 && killers_o == '0)); // R3
  AST_NO_SELF_VICTIM: assert property (@(posedge clk) disable iff (rst)
    !racers_o[CORE_ID] && !killers_o[CORE_ID]); // R3
endmodule

// File: rtl/tmc_commit_fsm.sv
module tmc_commit_fsm
  import tmc_pkg::*;
#(
  parameter int NCORES = 32,
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              begin_i,
  input  logic              commit_i,
  input  logic              labort_i,
  input  logic              rab_valid_i,
  input  logic [CW-1:0]     rab_src_i,
  input  logic              ack_valid_i,
  input  logic [CW-1:0]     ack_src_i,
  input  logic [NCORES-1:0] racers_i,
  output tx_st_e            state_o,
  output logic              clr_o,
  output logic              commit_done_o,
  output logic              aborted_o,
  output logic [NCORES-1:0] abort_vec_o,
  output logic              rab_ack_valid_o,
  output logic [CW-1:0]     rab_ack_dst_o
);
  tx_st_e            st_q, st_n;
  logic [NCORES-1:0] snap_q, snap_n, got_q, got_n, ack_hot, avec_n;
  logic              done_n, abt_n;

  assign ack_hot = ack_valid_i ? ((NCORES'(1) << ack_src_i) & snap_q) : '0;

  always_comb begin
    st_n   = st_q;
    snap_n = snap_q;
    got_n  = got_q;
    avec_n = '0;
    done_n = 1'b0;
    abt_n  = 1'b0;
    clr_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (begin_i) st_n = ST_RUN;
      ST_RUN: begin
        if (rab_valid_i || labort_i) begin
          clr_o = 1'b1; abt_n = 1'b1; st_n = ST_IDLE;
        end else if (commit_i) begin
          if (racers_i == '0) begin
            clr_o = 1'b1; done_n = 1'b1; st_n = ST_IDLE;
          end else begin
            avec_n = racers_i; snap_n = racers_i; got_n = '0; st_n = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (rab_valid_i) begin
          clr_o = 1'b1; abt_n = 1'b1; st_n = ST_IDLE;
        end else if ((got_q | ack_hot) == snap_q) begin
          clr_o = 1'b1; done_n = 1'b1; st_n = ST_IDLE;
        end else begin
          got_n = got_q | ack_hot;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q            <= ST_IDLE;
      snap_q          <= '0;
      got_q           <= '0;
      abort_vec_o     <= '0;
      commit_done_o   <= 1'b0;
      aborted_o       <= 1'b0;
      rab_ack_valid_o <= 1'b0;
      rab_ack_dst_o   <= '0;
    end else begin
      st_q            <= st_n;
      snap_q          <= snap_n;
      got_q           <= got_n;
      abort_vec_o     <= avec_n;
      commit_done_o   <= done_n;
      aborted_o       <= abt_n;
      rab_ack_valid_o <= rab_valid_i;
      rab_ack_dst_o   <= rab_src_i;
    end
  end

  assign state_o = st_q;

  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(commit_done_o && aborted_o)); // R9
  AST_ABORT_VEC_PULSE: assert property (@(posedge clk) disable iff (rst)
    (abort_vec_o != '0) |=> (abort_vec_o == '0)); // R7
  AST_ABORT_VEC_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    (abort_vec_o != '0) |-> (abort_vec_o == $past(racers_i))); // R7
  AST_DONE_NOT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    commit_done_o |-> ($past(st_q) != ST_IDLE)); // R6
endmodule

// File: rtl/tmc_tracker.sv
module tmc_tracker
  import tmc_pkg::*;
#(
  parameter int NCORES  = 32,
  parameter int NLINES  = 64,
  parameter int CORE_ID = 0,
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              tx_abort_i,
  input  logic              rd_i,
  input  logic [LW-1:0]     rd_line_i,
  input  logic              wr_i,
  input  logic [LW-1:0]     wr_line_i,
  input  logic              cf_valid_i,
  input  logic [CW-1:0]     cf_core_i,
  input  logic              cf_local_wr_i,
  input  logic              cf_remote_wr_i,
  input  logic              rab_valid_i,
  input  logic [CW-1:0]     rab_src_i,
  input  logic              ack_valid_i,
  input  logic [CW-1:0]     ack_src_i,
  input  logic [LW-1:0]     q_line_i,
  output logic              tx_active_o,
  output logic [NCORES-1:0] racers_o,
  output logic [NCORES-1:0] killers_o,
  output logic [NCORES-1:0] abort_vec_o,
  output logic              commit_done_o,
  output logic              aborted_o,
  output logic              rab_ack_valid_o,
  output logic [CW-1:0]     rab_ack_dst_o,
  output logic              q_sr_o,
  output logic              q_sm_o
);
  tx_st_e st;
  logic   clr, run, idle, rec_en;

  assign run    = (st == ST_RUN);
  assign idle   = (st == ST_IDLE);
  assign rec_en = run && !tx_commit_i;
  assign tx_active_o = !idle;

  tmc_commit_fsm #(.NCORES(NCORES)) u_fsm (
    .clk(clk), .rst(rst),
    .begin_i(tx_begin_i), .commit_i(tx_commit_i), .labort_i(tx_abort_i),
    .rab_valid_i(rab_valid_i), .rab_src_i(rab_src_i),
    .ack_valid_i(ack_valid_i), .ack_src_i(ack_src_i),
    .racers_i(racers_o),
    .state_o(st), .clr_o(clr),
    .commit_done_o(commit_done_o), .aborted_o(aborted_o),
    .abort_vec_o(abort_vec_o),
    .rab_ack_valid_o(rab_ack_valid_o), .rab_ack_dst_o(rab_ack_dst_o)
  );

  tmc_core_vecs #(.NCORES(NCORES), .CORE_ID(CORE_ID)) u_vecs (
    .clk(clk), .rst(rst), .clr_i(clr), .en_i(rec_en), .idle_i(idle),
    .cf_valid_i(cf_valid_i), .cf_core_i(cf_core_i),
    .cf_local_wr_i(cf_local_wr_i), .cf_remote_wr_i(cf_remote_wr_i),
    .racers_o(racers_o), .killers_o(killers_o)
  );

  tmc_line_sets #(.NLINES(NLINES)) u_lines (
    .clk(clk), .rst(rst), .clr_i(clr), .en_i(run), .idle_i(idle),
    .rd_i(rd_i), .rd_line_i(rd_line_i), .wr_i(wr_i), .wr_line_i(wr_line_i),
    .q_line_i(q_line_i), .q_sr_o(q_sr_o), .q_sm_o(q_sm_o)
  );

  AST_END_CLEARS_VECS: assert property (@(posedge clk) disable iff (rst)
    (commit_done_o || aborted_o) |-> (racers_o == '0 && killers_o == '0 && !tx_active_o)); // R10
endmodule

// File: tb/tb_tmc_tracker.sv
`timescale 1ns/1ps
module tb_tmc_tracker;
  localparam int NC = 32, NL = 64, SELF = 5;
  localparam int CW = $clog2(NC), LW = $clog2(NL);

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, rd = 0, wr = 0;
  logic [LW-1:0] rd_line = '0, wr_line = '0, q_line = '0;
  logic cf_valid = 0, cf_lw = 0, cf_rw = 0, rab_valid = 0, ack_valid = 0;
  logic [CW-1:0] cf_core = '0, rab_src = '0, ack_src = '0;
  logic tx_active, commit_done, aborted, rab_ack_valid, q_sr, q_sm;
  logic [NC-1:0] racers, killers, abort_vec;
  logic [CW-1:0] rab_ack_dst;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  tmc_tracker #(.NCORES(NC), .NLINES(NL), .CORE_ID(SELF)) dut (
    .clk(clk), .rst(rst), .tx_begin_i(tx_begin), .tx_commit_i(tx_commit),
    .tx_abort_i(tx_abort), .rd_i(rd), .rd_line_i(rd_line), .wr_i(wr),
    .wr_line_i(wr_line), .cf_valid_i(cf_valid), .cf_core_i(cf_core),
    .cf_local_wr_i(cf_lw), .cf_remote_wr_i(cf_rw), .rab_valid_i(rab_valid),
    .rab_src_i(rab_src), .ack_valid_i(ack_valid), .ack_src_i(ack_src),
    .q_line_i(q_line), .tx_active_o(tx_active), .racers_o(racers),
    .killers_o(killers), .abort_vec_o(abort_vec), .commit_done_o(commit_done),
    .aborted_o(aborted), .rab_ack_valid_o(rab_ack_valid),
    .rab_ack_dst_o(rab_ack_dst), .q_sr_o(q_sr), .q_sm_o(q_sm)
  );

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    tx_begin = 0; tx_commit = 0; tx_abort = 0; rd = 0; wr = 0;
    cf_valid = 0; cf_lw = 0; cf_rw = 0; rab_valid = 0; ack_valid = 0;
  endtask

  task automatic start_tx(); tx_begin = 1; cyc(); quiet(); endtask
  task automatic conflict(input int c, input logic lw, input logic rw);
    cf_valid = 1; cf_core = CW'(c); cf_lw = lw; cf_rw = rw; cyc(); quiet();
  endtask
  task automatic query(input int l, output logic sr, output logic sm);
    q_line = LW'(l); cyc(); sr = q_sr; sm = q_sm;
  endtask

  task automatic t_reset();
    chk("R1 active", tx_active, 0);
    chk("R1 racers", racers, 0);
    chk("R1 killers", killers, 0);
    chk("R1 pulses", {abort_vec != 0, commit_done, aborted, rab_ack_valid}, 0);
  endtask

  task automatic t_access();
    logic sr, sm;
    rd = 1; rd_line = 3; wr = 1; wr_line = 7; cyc(); quiet();
    query(3, sr, sm); chk("R2 idle access ignored", {sr, sm}, 2'b00);
    start_tx();
    rd = 1; rd_line = 3; wr = 1; wr_line = 7; cyc(); quiet();
    query(3, sr, sm); chk("R2 read sets sr", {sr, sm}, 2'b10);
    query(7, sr, sm); chk("R2 write sets sm", {sr, sm}, 2'b01);
    query(4, sr, sm); chk("R2 other line clear", {sr, sm}, 2'b00);
  endtask

  task automatic t_conflicts();
    conflict(11, 0, 0); chk("R3 read-read nothing", {racers, killers}, 0);
    conflict(SELF, 1, 1); chk("R3 self notice nothing", {racers, killers}, 0);
    conflict(2, 1, 0); chk("R4 racer set", racers, 64'h4);
    conflict(9, 0, 1); chk("R5 killer set", killers, 64'h200);
    conflict(20, 1, 1);
    chk("R5 ww racers", racers, 64'h0010_0004);
    chk("R5 ww killers", killers, 64'h0010_0200);
  endtask

  task automatic t_commit_racers();
    logic sr, sm;
    tx_commit = 1; cyc(); quiet();
    chk("R7 abort vector", abort_vec, 64'h0010_0004);
    chk("R7 still active", {tx_active, commit_done}, 2'b10);
    cyc(); chk("R7 pulse one cycle", abort_vec, 0);
    ack_valid = 1; ack_src = 20; cyc(); quiet();
    chk("R7 partial ack", commit_done, 0);
    ack_valid = 1; ack_src = 30; cyc(); quiet();
    chk("R7 stranger ack ignored", commit_done, 0);
    ack_valid = 1; ack_src = 2; cyc(); quiet();
    chk("R7 done after last ack", {commit_done, tx_active}, 2'b10);
    chk("R10 vectors clear", {racers, killers}, 0);
    cyc(); chk("R7 done one cycle", commit_done, 0);
    query(3, sr, sm); chk("R10 sr clear", sr, 0);
    query(7, sr, sm); chk("R10 sm clear", sm, 0);
  endtask

  task automatic t_commit_empty();
    start_tx();
    conflict(14, 0, 1);
    tx_commit = 1; cyc(); quiet();
    chk("R6 immediate done", {commit_done, aborted, tx_active}, 3'b100);
    chk("R6 no abort vector", abort_vec, 0);
    chk("R10 killers clear", killers, 0);
  endtask

  task automatic t_remote_abort();
    logic sr, sm;
    start_tx();
    wr = 1; wr_line = 9; cyc(); quiet();
    conflict(6, 1, 0);
    rab_valid = 1; rab_src = 17; cyc(); quiet();
    chk("R8 ack and abort", {rab_ack_valid, aborted, commit_done, tx_active}, 4'b1100);
    chk("R8 ack dest", rab_ack_dst, 17);
    chk("R10 racers clear", racers, 0);
    query(9, sr, sm); chk("R10 sm clear after abort", sm, 0);
    rab_valid = 1; rab_src = 4; cyc(); quiet();
    chk("R8 idle ack only", {rab_ack_valid, aborted, tx_active}, 3'b100);
    chk("R8 idle ack dest", rab_ack_dst, 4);
  endtask

  task automatic t_abort_in_wait();
    start_tx();
    conflict(3, 1, 0);
    tx_commit = 1; cyc(); quiet();
    ack_valid = 1; ack_src = 3; rab_valid = 1; rab_src = 7; cyc(); quiet();
    chk("R9 abort wins", {aborted, commit_done, tx_active}, 3'b100);
    chk("R9 ack dest", rab_ack_dst, 7);
    cyc(); chk("R9 no later done", commit_done, 0);
  endtask

  task automatic t_local_abort();
    logic sr, sm;
    start_tx();
    rd = 1; rd_line = 12; cyc(); quiet();
    conflict(1, 1, 1);
    tx_abort = 1; cyc(); quiet();
    chk("R11 local abort", {aborted, commit_done, tx_active, rab_ack_valid}, 4'b1000);
    chk("R11 vectors dropped", {racers, killers}, 0);
    query(12, sr, sm); chk("R11 sr dropped", sr, 0);
    conflict(8, 1, 0); chk("R3 idle notice ignored", racers, 0);
  endtask

  initial begin
    repeat (4) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_access();
    t_conflicts();
    t_commit_racers();
    t_commit_empty();
    t_remote_abort();
    t_abort_in_wait();
    t_local_abort();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule